// File: doc/BRIEF.md
# Data-Hazard and Bypass Control for a Six-Stage Pipeline

This block decides, for every instruction about to leave the decode stage of an in-order pipeline with stages IF, ID, EX1, EX2, M and WB, whether each source operand can be supplied in time. Simple ALU operations (add, subtract, logic) finish at the end of EX1. Multiplies finish one stage later, at the end of EX2. Loads deliver their data only at the end of M. The unit keeps a small shadow record of the destination register and operation class of each instruction in EX1, EX2, M and WB. It compares that record with the source registers of the decode-stage instruction.

When a needed value can be reached through a bypass path that exists in the chosen configuration, the unit registers a select code for that operand's EX1 input multiplexer. When it cannot, the unit raises a stall in the same cycle. The stall holds the PC and the IF/ID register, and a bubble enters EX1 while the older stages keep moving. The stall repeats until the producer has moved far enough for an enabled path to reach it. A parameter selects one of four path sets: full bypass, M-output bypass only, register-file write-through only, or no forwarding at all.

Top module: `hzu_six_stage`

## Requirements
- R1: After a synchronous reset with no valid instruction in decode, `stall`, `ex1_bubble`, `fwd_a` and `fwd_b` are all 0.
- R2: A source register number of 0 never causes a stall or a bypass select other than 0, and a destination of 0 is never tracked as a producer.
- R3: In full mode, an operand written by the ALU instruction directly ahead causes no stall, and the select for that operand is 1 (EX1 output) on the cycle after issue.
- R4: In full mode, an operand written by the multiply directly ahead stalls exactly one cycle, and then the select is 2 (EX2 output).
- R5: In full mode, an operand written by the load directly ahead stalls exactly two cycles, and then the select is 3 (M output). A load two ahead stalls one cycle, and then the select is 3. A multiply two ahead gives select 2 with no stall.
- R6: When more than one in-flight instruction writes the same register, only the youngest producer decides the stall and the select.
- R7: A stall is raised only for a valid decode instruction. The cycle after a stall, `ex1_bubble` is 1 and both selects are 0.
- R8: A producer in WB is read through the register file in the same cycle when write-through is enabled (no stall, select 0). Without write-through it costs one stall cycle.
- R9: In the M-only mode (FWD_MODE=1), every select is 0 or 3. An ALU, multiply or load producer directly ahead costs two stall cycles and then gives select 3.
- R10: In the write-through-only mode (FWD_MODE=2), selects stay 0. A producer directly ahead costs three stall cycles.
- R11: In the no-forwarding mode (FWD_MODE=3), selects stay 0. A producer directly ahead costs four stall cycles.
- R12: A source whose use flag is 0 never causes a stall or a bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | REG_AW | First source register |
| id_rs1_used | input | 1 | First source is read |
| id_rs2 | input | REG_AW | Second source register |
| id_rs2_used | input | 1 | Second source is read |
| id_rd | input | REG_AW | Destination register |
| id_rd_write | input | 1 | Instruction writes its destination |
| id_kind | input | 2 | Result class: 0 ALU, 1 multiply, 2 load |
| stall | output | 1 | Hold PC and IF/ID, inject a bubble into EX1 |
| ex1_bubble | output | 1 | EX1 currently holds an injected bubble |
| fwd_a | output | 2 | First operand select: 0 register file, 1 EX1 out, 2 EX2 out, 3 M out |
| fwd_b | output | 2 | Second operand select, same coding |

## Verification
`stall` is a function of the decode inputs and the shadow record, so it is due in the same cycle the consumer is presented. The bench reads it one time unit after the falling edge on which the inputs change. The selects and `ex1_bubble` are registered at the rising edge that moves the instruction into EX1. The bench reads them after the next falling edge, that is, after the first cycle in which `stall` is low. Bubble counts are the run of consecutive stall cycles from first presentation. Four instances, one per mode, see the same stimulus, so each dependency distance is checked against all four path sets at once.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

  // result classes of the decode-stage instruction
  localparam logic [1:0] KIND_ALU  = 2'd0;
  localparam logic [1:0] KIND_MUL  = 2'd1;
  localparam logic [1:0] KIND_LOAD = 2'd2;

  // operand select codes; codes 1..3 equal the producer distance
  localparam logic [1:0] SRC_RF  = 2'd0;
  localparam logic [1:0] SRC_EX1 = 2'd1;
  localparam logic [1:0] SRC_EX2 = 2'd2;
  localparam logic [1:0] SRC_MEM = 2'd3;

  // path configurations
  localparam int unsigned MODE_FULL = 0;
  localparam int unsigned MODE_MEM  = 1;
  localparam int unsigned MODE_RF   = 2;
  localparam int unsigned MODE_NONE = 3;

  // tracked stages behind decode: EX1, EX2, M, WB
  localparam int NUM_TRACK = 4;

  // bit d enables the path to a producer at distance d+1
  // bit0 EX1 out, bit1 EX2 out, bit2 M out, bit3 register-file write-through
  function automatic logic [NUM_TRACK-1:0] path_mask(int unsigned mode);
    case (mode)
      MODE_FULL: return 4'b1111;
      MODE_MEM:  return 4'b0100;
      MODE_RF:   return 4'b1000;
      default:   return 4'b0000;
    endcase
  endfunction

  // number of stages after decode by whose end the result exists
  function automatic int kind_ready(logic [1:0] kind);
    case (kind)
      KIND_ALU: return 1;
      KIND_MUL: return 2;
      default:  return 3;
    endcase
  endfunction

endpackage

// File: rtl/hzu_track.sv
module hzu_track import hzu_pkg::*; #(
  parameter int AW   = 5,
  parameter int NSTG = NUM_TRACK
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ins_vld,
  input  logic [AW-1:0]             ins_rd,
  input  logic [1:0]                ins_kind,
  output logic [NSTG-1:0]           stg_vld,
  output logic [NSTG-1:0][AW-1:0]   stg_rd,
  output logic [NSTG-1:0][1:0]      stg_kind
);

  logic          vld_q  [NSTG];
  logic [AW-1:0] rd_q   [NSTG];
  logic [1:0]    kind_q [NSTG];

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    logic          nxt_v;
    logic [AW-1:0] nxt_r;
    logic [1:0]    nxt_k;

    if (s == 0) begin : g_head
      assign nxt_v = ins_vld;
      assign nxt_r = ins_rd;
      assign nxt_k = ins_kind;
    end else begin : g_body
      assign nxt_v = vld_q[s-1];
      assign nxt_r = rd_q[s-1];
      assign nxt_k = kind_q[s-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[s]  <= 1'b0;
        rd_q[s]   <= '0;
        kind_q[s] <= KIND_ALU;
      end else begin
        vld_q[s]  <= nxt_v;
        rd_q[s]   <= nxt_r;
        kind_q[s] <= nxt_k;
      end
    end

    assign stg_vld[s]  = vld_q[s];
    assign stg_rd[s]   = rd_q[s];
    assign stg_kind[s] = kind_q[s];
  end

endmodule

// File: rtl/hzu_resolve.sv
module hzu_resolve import hzu_pkg::*; #(
  parameter int                    AW    = 5,
  parameter int                    NSTG  = NUM_TRACK,
  parameter logic [NUM_TRACK-1:0]  PATHS = 4'b1111
) (
  input  logic [AW-1:0]             src,
  input  logic                      used,
  input  logic [NSTG-1:0]           stg_vld,
  input  logic [NSTG-1:0][AW-1:0]   stg_rd,
  input  logic [NSTG-1:0][1:0]      stg_kind,
  output logic                      need_stall,
  output logic [1:0]                sel
);

  logic hit;

  // scan from the youngest producer outward; the first match decides
  always_comb begin
    hit        = 1'b0;
    need_stall = 1'b0;
    sel        = SRC_RF;
    for (int d = 0; d < NSTG; d++) begin
      if (!hit && used && (src != '0) && stg_vld[d] && (stg_rd[d] == src)) begin
        hit = 1'b1;
        if (PATHS[d] && (kind_ready(stg_kind[d]) <= d + 1)) begin
          sel = (d + 1 < NSTG) ? 2'(d + 1) : SRC_RF;
        end else begin
          need_stall = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hzu_six_stage.sv
module hzu_six_stage import hzu_pkg::*; #(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned FWD_MODE = MODE_FULL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic              id_rs1_used,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_rs2_used,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_rd_write,
  input  logic [1:0]        id_kind,
  output logic              stall,
  output logic              ex1_bubble,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b
);

  localparam logic [NUM_TRACK-1:0] PATHS = path_mask(FWD_MODE);
  localparam int                   NOPS  = 2;

  logic                               stall_c;
  logic                               issue;
  logic                               trk_in_vld;
  logic [NUM_TRACK-1:0]               stg_vld;
  logic [NUM_TRACK-1:0][REG_AW-1:0]   stg_rd;
  logic [NUM_TRACK-1:0][1:0]          stg_kind;

  logic [REG_AW-1:0] op_src  [NOPS];
  logic              op_used [NOPS];
  logic              op_stall[NOPS];
  logic [1:0]        op_sel  [NOPS];

  assign op_src[0]  = id_rs1;
  assign op_used[0] = id_rs1_used;
  assign op_src[1]  = id_rs2;
  assign op_used[1] = id_rs2_used;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    hzu_resolve #(
      .AW   (REG_AW),
      .NSTG (NUM_TRACK),
      .PATHS(PATHS)
    ) u_res (
      .src       (op_src[k]),
      .used      (op_used[k]),
      .stg_vld   (stg_vld),
      .stg_rd    (stg_rd),
      .stg_kind  (stg_kind),
      .need_stall(op_stall[k]),
      .sel       (op_sel[k])
    );
  end

  assign stall_c    = id_valid && (op_stall[0] || op_stall[1]);
  assign issue      = id_valid && !stall_c;
  assign trk_in_vld = issue && id_rd_write && (id_rd != '0);
  assign stall      = stall_c;

  hzu_track #(
    .AW  (REG_AW),
    .NSTG(NUM_TRACK)
  ) u_trk (
    .clk     (clk),
    .rst     (rst),
    .ins_vld (trk_in_vld),
    .ins_rd  (id_rd),
    .ins_kind(id_kind),
    .stg_vld (stg_vld),
    .stg_rd  (stg_rd),
    .stg_kind(stg_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ex1_bubble <= 1'b0;
      fwd_a      <= SRC_RF;
      fwd_b      <= SRC_RF;
    end else begin
      ex1_bubble <= stall_c;
      fwd_a      <= issue ? op_sel[0] : SRC_RF;
      fwd_b      <= issue ? op_sel[1] : SRC_RF;
    end
  end

endmodule

// File: rtl/hzu_six_stage_chk.sv
module hzu_six_stage_chk import hzu_pkg::*; #(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned FWD_MODE = MODE_FULL
) (
  input logic              clk,
  input logic              rst,
  input logic              id_valid,
  input logic [REG_AW-1:0] id_rs1,
  input logic              id_rs1_used,
  input logic [REG_AW-1:0] id_rs2,
  input logic              id_rs2_used,
  input logic              stall,
  input logic              ex1_bubble,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b
);

  // R1, R7: no stall without a decode instruction
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> !stall);

  // R2 and R12: sources that are zero or unread never stall
  p_zero_src_r2: assert property (@(posedge clk) disable iff (rst)
    (id_valid && (!id_rs1_used || id_rs1 == '0) && (!id_rs2_used || id_rs2 == '0))
      |-> !stall);

  // R7: the cycle after a stall, EX1 is a bubble with neutral selects
  p_bubble_sel_r7: assert property (@(posedge clk) disable iff (rst)
    stall |=> (ex1_bubble && fwd_a == SRC_RF && fwd_b == SRC_RF));

  if (FWD_MODE == MODE_MEM) begin : g_mem
    // R9: only the M output path may be selected
    p_mem_paths_r9: assert property (@(posedge clk) disable iff (rst)
      ((fwd_a == SRC_RF || fwd_a == SRC_MEM) && (fwd_b == SRC_RF || fwd_b == SRC_MEM)));
  end else if (FWD_MODE == MODE_RF) begin : g_rf
    // R10: no bypass path is ever selected
    p_rf_paths_r10: assert property (@(posedge clk) disable iff (rst)
      (fwd_a == SRC_RF && fwd_b == SRC_RF));
  end else if (FWD_MODE == MODE_NONE) begin : g_none
    // R11: no bypass path is ever selected
    p_none_paths_r11: assert property (@(posedge clk) disable iff (rst)
      (fwd_a == SRC_RF && fwd_b == SRC_RF));
  end

endmodule

bind hzu_six_stage hzu_six_stage_chk #(
  .REG_AW  (REG_AW),
  .FWD_MODE(FWD_MODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .id_valid   (id_valid),
  .id_rs1     (id_rs1),
  .id_rs1_used(id_rs1_used),
  .id_rs2     (id_rs2),
  .id_rs2_used(id_rs2_used),
  .stall      (stall),
  .ex1_bubble (ex1_bubble),
  .fwd_a      (fwd_a),
  .fwd_b      (fwd_b)
);

// File: tb/sim_hzu_six_stage.sv
module sim_hzu_six_stage;
  import hzu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          id_valid;
  logic [AW-1:0] id_rs1, id_rs2, id_rd;
  logic          id_rs1_used, id_rs2_used, id_rd_write;
  logic [1:0]    id_kind;

  logic       stall_w [ND];
  logic       bub_w   [ND];
  logic [1:0] fa_w    [ND];
  logic [1:0] fb_w    [ND];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // one instance per mode: 0 full, 1 M only, 2 write-through only, 3 none
  for (genvar g = 0; g < ND; g++) begin : gm
    hzu_six_stage #(.REG_AW(AW), .FWD_MODE(g)) u0 (
      .clk(clk), .rst(rst), .id_valid(id_valid),
      .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
      .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
      .id_rd(id_rd), .id_rd_write(id_rd_write), .id_kind(id_kind),
      .stall(stall_w[g]), .ex1_bubble(bub_w[g]),
      .fwd_a(fa_w[g]), .fwd_b(fb_w[g])
    );
  end

  task automatic chk_eq(string req, string what, int mode, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s mode %0d: actual %0d expected %0d", req, what, mode, act, exp);
    end
  endtask

  task automatic idle_in();
    id_valid = 0; id_rs1 = '0; id_rs2 = '0; id_rd = '0;
    id_rs1_used = 0; id_rs2_used = 0; id_rd_write = 0; id_kind = KIND_ALU;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle_in();
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic produce(logic [AW-1:0] rd, logic [1:0] kind);
    @(negedge clk);
    idle_in();
    id_valid = 1; id_rd = rd; id_rd_write = 1; id_kind = kind;
  endtask

  task automatic gap();
    @(negedge clk);
    idle_in();
  endtask

  // present a consumer and measure per mode: bubble count and select after issue
  task automatic consume(string req, logic [AW-1:0] rs, bit opb, bit use_src,
                         logic [ND-1:0][2:0] eb, logic [ND-1:0][1:0] ef);
    int bub[ND];
    int fw[ND];
    bit done[ND];
    bit cap[ND];
    bit prev[ND];
    @(negedge clk);
    idle_in();
    id_valid = 1;
    if (opb) begin id_rs2 = rs; id_rs2_used = use_src; end
    else     begin id_rs1 = rs; id_rs1_used = use_src; end
    for (int d = 0; d < ND; d++) begin
      bub[d] = 0; fw[d] = -1; done[d] = 0; cap[d] = 0; prev[d] = 0;
    end
    for (int k = 0; k < 9; k++) begin
      #1;
      for (int d = 0; d < ND; d++) begin
        if (cap[d]) begin
          fw[d] = opb ? int'(fb_w[d]) : int'(fa_w[d]);
          cap[d] = 0;
        end
        if (prev[d]) begin
          // R7: bubble in EX1 with neutral selects after each stall cycle
          chk_eq("R7", "bubble flag after stall", d, int'(bub_w[d]), 1);
          chk_eq("R7", "selects after stall", d, int'(fa_w[d]) + int'(fb_w[d]), 0);
        end
        prev[d] = stall_w[d];
        if (!done[d]) begin
          if (stall_w[d]) bub[d]++;
          else begin done[d] = 1; cap[d] = 1; end
        end
      end
      @(negedge clk);
    end
    for (int d = 0; d < ND; d++) begin
      chk_eq(req, "stall cycles", d, bub[d], int'(eb[d]));
      chk_eq(req, "operand select", d, fw[d], int'(ef[d]));
    end
    idle_in();
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    for (int d = 0; d < ND; d++) begin
      chk_eq("R1", "stall", d, int'(stall_w[d]), 0);
      chk_eq("R1", "ex1_bubble", d, int'(bub_w[d]), 0);
      chk_eq("R1", "fwd_a", d, int'(fa_w[d]), 0);
      chk_eq("R1", "fwd_b", d, int'(fb_w[d]), 0);
    end
  endtask

  // expected vectors are listed mode 3, 2, 1, 0
  task automatic t_alu_adjacent();
    do_reset();
    produce(5'd9, KIND_ALU);
    consume("R3 R9 R10 R11", 5'd9, 0, 1, {3'd4, 3'd3, 3'd2, 3'd0}, {2'd0, 2'd0, 2'd3, 2'd1});
  endtask

  task automatic t_mul_adjacent();
    do_reset();
    produce(5'd12, KIND_MUL);
    consume("R4 R9", 5'd12, 1, 1, {3'd4, 3'd3, 3'd2, 3'd1}, {2'd0, 2'd0, 2'd3, 2'd2});
  endtask

  task automatic t_load_adjacent();
    do_reset();
    produce(5'd29, KIND_LOAD);
    consume("R5 R9", 5'd29, 0, 1, {3'd4, 3'd3, 3'd2, 3'd2}, {2'd0, 2'd0, 2'd3, 2'd3});
  endtask

  task automatic t_mul_two_back();
    do_reset();
    produce(5'd14, KIND_MUL);
    gap();
    consume("R5", 5'd14, 0, 1, {3'd3, 3'd2, 3'd1, 3'd0}, {2'd0, 2'd0, 2'd3, 2'd2});
  endtask

  task automatic t_load_two_back();
    do_reset();
    produce(5'd25, KIND_LOAD);
    gap();
    consume("R5", 5'd25, 1, 1, {3'd3, 3'd2, 3'd1, 3'd1}, {2'd0, 2'd0, 2'd3, 2'd3});
  endtask

  task automatic t_wb_distance();
    do_reset();
    produce(5'd10, KIND_ALU);
    gap(); gap(); gap();
    consume("R8", 5'd10, 0, 1, {3'd1, 3'd0, 3'd1, 3'd0}, {2'd0, 2'd0, 2'd0, 2'd0});
  endtask

  task automatic t_zero_reg();
    do_reset();
    produce(5'd0, KIND_LOAD);
    consume("R2", 5'd0, 0, 1, {3'd0, 3'd0, 3'd0, 3'd0}, {2'd0, 2'd0, 2'd0, 2'd0});
  endtask

  task automatic t_youngest();
    do_reset();
    produce(5'd7, KIND_LOAD);
    produce(5'd7, KIND_ALU);
    consume("R6", 5'd7, 0, 1, {3'd4, 3'd3, 3'd2, 3'd0}, {2'd0, 2'd0, 2'd3, 2'd1});
  endtask

  task automatic t_unused_src();
    do_reset();
    produce(5'd19, KIND_LOAD);
    consume("R12", 5'd19, 1, 0, {3'd0, 3'd0, 3'd0, 3'd0}, {2'd0, 2'd0, 2'd0, 2'd0});
  endtask

  initial begin
    rst = 1;
    idle_in();
    t_reset();
    t_alu_adjacent();
    t_mul_adjacent();
    t_load_adjacent();
    t_mul_two_back();
    t_load_two_back();
    t_wb_distance();
    t_zero_reg();
    t_youngest();
    t_unused_src();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule